// File: doc/BRIEF.md
# Fault-Injectable Three-Input Truth-Table Cell

This block is one combinational logic cell that evaluates any boolean function of three inputs. The function comes from an eight-entry truth table fixed by a parameter. Input `in_a` is the most significant bit of the table index and `in_c` the least significant. The parameter word holds entry 7 in its top bit and entry 0 in its bottom bit. A majority function is therefore `8'b11101000`, a three-input AND is `8'b10000000` and a three-input XOR is `8'b10010110`.

Every instance carries a numeric identity, `CELL_ID`. Number 0 is reserved to mean "no cell". All cells of a design share one fault-selection bus. The bus names a cell number and one table entry, and it chooses between two modes. In corrupt mode the selected entry is inverted, so the cell computes a different function. In observe mode the entry keeps its value, and the `mark` output is raised whenever that entry is the one being looked up. A testbench can therefore sweep every single-entry functional fault across a netlist, and it can see which table entries its stimulus actually reaches.

The selection bus is captured in a register on the rising clock edge. A change on the bus can therefore not disturb the function output until that edge. Reset clears the captured selection.

Top module: `fault_lut3_cell`

## Requirements
- R1: With no captured selection, `y` equals table entry `{in_a,in_b,in_c}` of `TRUTH` (in_a is index bit 2).
- R2: A cell is selected only when `inj_en` is 1, `inj_gate` equals `CELL_ID`, and `inj_gate` is not 0. A mismatching number, or an enable of 0, leaves the cell unaffected.
- R3: In corrupt mode (`inj_obs` = 0), only the selected entry is inverted. All other indices give their normal value.
- R4: In observe mode (`inj_obs` = 1), `y` keeps the normal table value. `mark` is 1 exactly when the current index equals the selected entry.
- R5: `mark` is 0 whenever the cell is not selected, or is selected in corrupt mode.
- R6: `inj_bit` is a 4-bit two's-complement number. Negative values, including -1 (4'hF) and -8 (4'h8), select no entry, and the cell behaves as unselected.
- R7: A new bus value affects `y` and `mark` only from the first rising clock edge after it is applied.
- R8: While `rst_n` is 0, the captured selection is cleared and the cell behaves as unselected, whatever the bus shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that captures the selection bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Function input, index bit 2 |
| in_b | input | 1 | Function input, index bit 1 |
| in_c | input | 1 | Function input, index bit 0 |
| inj_en | input | 1 | Fault selection enable |
| inj_gate | input | ID_W | Number of the cell being selected |
| inj_bit | input | 4 | Signed table entry number |
| inj_obs | input | 1 | Mode: 0 corrupt, 1 observe |
| y | output | 1 | Function value |
| mark | output | 1 | High when the observed entry is in use |

## Verification
The bench sets the selection on the cell's own number and then looks at the selected index and its neighbours. A design that inverted the whole table, or the wrong entry, would fail at a neighbouring index. Negative entry numbers are applied, because a design that truncated the sign would corrupt entry 7 or entry 0. The bench also checks `y` one instant before the capturing edge and one instant after it: a combinational path from the bus would change the output early. Finally, a corrupting selection is held active through reset, which catches a reset that fails to clear the captured state.

// File: rtl/fl3_pkg.sv
package fl3_pkg;
  localparam int IDX_W = 3;
  localparam int ENTRIES = 1 << IDX_W;

  typedef struct packed {
    logic             hit;
    logic             obs;
    logic [IDX_W-1:0] idx;
  } fl3_sel_t;
endpackage

// File: rtl/fl3_decode.sv
module fl3_decode
  import fl3_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int CELL_ID = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inj_en,
  input  logic [ID_W-1:0]   inj_gate,
  input  logic signed [3:0] inj_bit,
  input  logic              inj_obs,
  output fl3_sel_t          sel_d
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(CELL_ID);

  logic id_match;
  logic bit_ok;

  always_comb begin
    id_match  = inj_en && (inj_gate == MY_ID) && (inj_gate != '0);
    bit_ok    = (inj_bit >= 0);
    sel_d.hit = id_match && bit_ok;
    sel_d.obs = inj_obs;
    sel_d.idx = inj_bit[IDX_W-1:0];
  end

  assert_neg_bit_unsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inj_bit[3] |-> !sel_d.hit);
  assert_select_needs_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_d.hit |-> (inj_en && inj_gate == MY_ID && inj_gate != '0));
endmodule

// File: rtl/fl3_sel_reg.sv
module fl3_sel_reg
  import fl3_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_en,
  input  fl3_sel_t sel_d,
  output fl3_sel_t sel_q
);
  fl3_sel_t sel_nx;

  always_comb begin
    sel_nx = sel_q;
    if (load_en) sel_nx = sel_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_nx;
  end

  assert_capture_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (sel_q == $past(sel_d)));
  assert_reset_clears_R8: assert property (@(posedge clk)
    !rst_n |-> !sel_q.hit);
endmodule

// File: rtl/fl3_eval.sv
module fl3_eval
  import fl3_pkg::*;
#(
  parameter logic [ENTRIES-1:0] TRUTH = 8'b1110_1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  fl3_sel_t         sel_q,
  output logic             y,
  output logic             mark
);
  logic [ENTRIES-1:0] flip_mask;
  logic [ENTRIES-1:0] eff_table;
  logic               at_sel;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_mask
    assign flip_mask[e] = sel_q.hit && !sel_q.obs && (sel_q.idx == IDX_W'(e));
  end

  always_comb begin
    eff_table = TRUTH ^ flip_mask;
    at_sel    = (idx == sel_q.idx);
    y         = eff_table[idx];
    mark      = sel_q.hit && sel_q.obs && at_sel;
  end

  assert_unsel_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q.hit |-> (y == TRUTH[idx]));
  assert_alter_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q.hit && !sel_q.obs && idx == sel_q.idx) |-> (y != TRUTH[idx]));
  assert_observe_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q.hit && sel_q.obs) |-> (y == TRUTH[idx]));
  assert_mark_only_observe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mark |-> (sel_q.hit && sel_q.obs));
endmodule

// File: rtl/fault_lut3_cell.sv
module fault_lut3_cell
  import fl3_pkg::*;
#(
  parameter logic [7:0] TRUTH   = 8'b1110_1000,
  parameter int         CELL_ID = 1,
  parameter int         ID_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_c,
  input  logic              inj_en,
  input  logic [ID_W-1:0]   inj_gate,
  input  logic signed [3:0] inj_bit,
  input  logic              inj_obs,
  output logic              y,
  output logic              mark
);
  fl3_sel_t         sel_d;
  fl3_sel_t         sel_q;
  logic [IDX_W-1:0] idx;

  assign idx = {in_a, in_b, in_c};

  fl3_decode #(.ID_W(ID_W), .CELL_ID(CELL_ID)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .inj_en   (inj_en),
    .inj_gate (inj_gate),
    .inj_bit  (inj_bit),
    .inj_obs  (inj_obs),
    .sel_d    (sel_d)
  );

  fl3_sel_reg u_sel_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (1'b1),
    .sel_d   (sel_d),
    .sel_q   (sel_q)
  );

  fl3_eval #(.TRUTH(TRUTH)) u_eval (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (idx),
    .sel_q (sel_q),
    .y     (y),
    .mark  (mark)
  );
endmodule

// File: tb/fault_lut3_cell_bench.sv
module fault_lut3_cell_bench;
  localparam int CLK_P = 10;
  localparam int NV = 15;
  // {en, gate[7:0], bit[3:0], obs, abc[2:0], exp_y, exp_mark}; cell is MAJ3, id 5
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 8'd0, 4'h0, 1'b0, 3'b000, 1'b0, 1'b0}, // R1
    {1'b0, 8'd0, 4'h0, 1'b0, 3'b011, 1'b1, 1'b0}, // R1
    {1'b0, 8'd0, 4'h0, 1'b0, 3'b101, 1'b1, 1'b0}, // R1
    {1'b0, 8'd0, 4'h0, 1'b0, 3'b100, 1'b0, 1'b0}, // R1
    {1'b1, 8'd5, 4'h3, 1'b0, 3'b011, 1'b0, 1'b0}, // R3 flip
    {1'b1, 8'd5, 4'h3, 1'b0, 3'b010, 1'b0, 1'b0}, // R3 neighbour
    {1'b1, 8'd5, 4'h3, 1'b1, 3'b011, 1'b1, 1'b1}, // R4
    {1'b1, 8'd5, 4'h3, 1'b1, 3'b111, 1'b1, 1'b0}, // R4
    {1'b1, 8'd4, 4'h3, 1'b0, 3'b011, 1'b1, 1'b0}, // R2 other id
    {1'b1, 8'd5, 4'hF, 1'b0, 3'b111, 1'b1, 1'b0}, // R6 -1
    {1'b1, 8'd5, 4'h8, 1'b0, 3'b000, 1'b0, 1'b0}, // R6 -8
    {1'b0, 8'd5, 4'h3, 1'b0, 3'b011, 1'b1, 1'b0}, // R2 enable off
    {1'b1, 8'd5, 4'h0, 1'b0, 3'b000, 1'b1, 1'b0}, // R3 entry 0
    {1'b1, 8'd5, 4'h7, 1'b0, 3'b111, 1'b0, 1'b0}, // R3 entry 7
    {1'b1, 8'd0, 4'h3, 1'b1, 3'b011, 1'b1, 1'b0}  // R5 id 0
  };

  logic clk = 1'b0;
  logic rst_n, in_a, in_b, in_c, inj_en, inj_obs, y, mark;
  logic [7:0] inj_gate;
  logic signed [3:0] inj_bit;
  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  fault_lut3_cell #(.TRUTH(8'b1110_1000), .CELL_ID(5), .ID_W(8)) u_fault_lut3_cell (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .inj_en(inj_en), .inj_gate(inj_gate), .inj_bit(inj_bit), .inj_obs(inj_obs),
    .y(y), .mark(mark)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_bus(input logic en, input logic [7:0] g, input logic [3:0] b, input logic o);
    @(negedge clk);
    inj_en = en; inj_gate = g; inj_bit = b; inj_obs = o;
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {in_a, in_b, in_c} = 3'b011;
    inj_en = 1'b1; inj_gate = 8'd5; inj_bit = 4'sd3; inj_obs = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 reset y", y, 1'b1);
    check("R8 reset mark", mark, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    set_bus(1'b0, 8'd0, 4'h0, 1'b0);
    @(posedge clk); #1;

    for (int i = 0; i < NV; i++) begin
      set_bus(VEC[i][18], VEC[i][17:10], VEC[i][9:6], VEC[i][5]);
      @(posedge clk); #1;
      {in_a, in_b, in_c} = VEC[i][4:2];
      #1;
      check($sformatf("R1-vector%0d y", i), y, VEC[i][1]);
      check($sformatf("R5-vector%0d mark", i), mark, VEC[i][0]);
    end

    // R7: bus change has no effect before the capturing edge
    set_bus(1'b0, 8'd0, 4'h0, 1'b0);
    @(posedge clk); #1;
    {in_a, in_b, in_c} = 3'b101;
    set_bus(1'b1, 8'd5, 4'h5, 1'b0);
    #1;
    check("R7 before edge", y, 1'b1);
    @(posedge clk); #1;
    check("R7 after edge", y, 1'b0);
    // R4: observe mark follows the index combinationally
    set_bus(1'b1, 8'd5, 4'h5, 1'b1);
    @(posedge clk); #1;
    check("R4 mark at entry", mark, 1'b1);
    {in_a, in_b, in_c} = 3'b110; #1;
    check("R4 mark elsewhere", mark, 1'b0);
    check("R4 value kept", y, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule